// File: doc/BRIEF.md
# Vector element move unit

This unit executes the element-addressed group of a 128-bit SIMD extension. It receives one 32-bit instruction word that the front end has already steered to this group, together with the operands it needs: the source vector register value, the current value of the destination vector register and one general-purpose register (GPR) value. It decodes a 6-bit field in which a prefix code gives the element size and the remaining bits give the lane number. It then produces one of three results:

- a lane copied out to a GPR, with either sign or zero extension;
- a GPR value placed into one lane of a vector;
- lane 0 of another vector placed into one lane of a vector.

Illegal encodings are reported as a reserved-instruction exception. One escape value of the field is reported separately, so that the control-register and whole-vector-move path can take the instruction.

Results leave through a registered output stage as writeback strobes, a register number and data. Both the input and the output use a valid/ready handshake. A new instruction is accepted whenever the output register is empty or is being drained in the same cycle. The parameter `GPR_W` (32 or 64) selects the width of the scalar side.

Top module: `elm_move_unit`

## Requirements
- R1: The format/index field is `instr[21:16]`, the source register number is `instr[15:11]` and the destination register number is `instr[10:6]`. A field value of the form `00nnnn` selects 8-bit lanes, with lane number `nnnn`.
- R2: A field value of the form `100nnn` selects 16-bit lanes, with lane number `nnn`.
- R3: A field value of the form `1100nn` selects 32-bit lanes, with lane number `nn`.
- R4: A field value of the form `11100n` selects 64-bit lanes, with lane number `n`.
- R5: The field value `0x3E` raises `ctl_escape` whatever the operation code is. It writes nothing and raises no exception.
- R6: Every other field value (`0x10`–`0x1F`, `0x28`–`0x2F`, `0x34`–`0x37`, `0x3A`–`0x3D`, `0x3F`) raises `ri_exc` with both write strobes low.
- R7: The operation code is `instr[25:22]`:
  - 2 is copy-signed;
  - 3 is copy-unsigned;
  - 4 is insert-from-GPR;
  - 5 is insert-from-vector.

  Any other code with a valid lane field raises `ri_exc`.
- R8: Copy-signed raises `gpr_we` and writes the selected lane of `vs_data`, sign-extended to `GPR_W` bits, to GPR number `instr[10:6]`. Lane k occupies bits `[k*size +: size]`, and the lane number always lies within the lane count of its format.
- R9: Copy-unsigned does the same as copy-signed but zero-extends the lane.
- R10: Insert-from-GPR raises `vr_we` and writes `vd_data`, with the selected lane replaced by the low lane-size bits of `gpr_data`, to vector register `instr[10:6]`. All other lanes are unchanged.
- R11: Insert-from-vector replaces the selected lane of `vd_data` with lane 0 of `vs_data`, leaving the other lanes unchanged.
- R12: With `GPR_W` = 32, copy and insert-from-GPR on 64-bit lanes raise `ri_exc`. Insert-from-vector on 64-bit lanes stays legal.
- R13: `in_ready` is high when the output stage is empty or `out_ready` is high. A result is presented on the cycle after acceptance and is held unchanged while `out_ready` is low.
- R14: Write data buses are zero whenever their strobe is low, and the reset state has `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction and operands are present |
| in_ready | output | 1 | Unit can accept an instruction |
| instr | input | 32 | Instruction word |
| vs_data | input | 128 | Source vector register value |
| vd_data | input | 128 | Current destination vector register value |
| gpr_data | input | GPR_W | Source GPR value |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result |
| gpr_we | output | 1 | GPR write strobe |
| vr_we | output | 1 | Vector register write strobe |
| wb_addr | output | 5 | Destination register number |
| gpr_wdata | output | GPR_W | GPR write data |
| vr_wdata | output | 128 | Vector register write data |
| ri_exc | output | 1 | Reserved-instruction exception |
| ctl_escape | output | 1 | Escape group selected |

## Verification
Every one of the 64 field values is crossed with all 16 operation codes, on a 64-bit and a 32-bit instance side by side. This sweep separates:

- lane-size decoding from lane-number decoding;
- reserved field values from unused operation codes;
- the escape value from both kinds of exception.

The operand patterns differ in the sign bit of each lane, so sign extension is distinguished from zero extension. The destination vector differs from the source in every byte, so a merge that disturbs a neighbouring lane shows up. A stall sequence, in which a second instruction waits behind an unconsumed result, tells holding apart from overwriting.

// File: rtl/elm_move_pkg.sv
package elm_move_pkg;

    localparam int VEC_W = 128;
    localparam int NFMT  = 4;

    typedef enum logic [1:0] {
        FMT_B = 2'd0,
        FMT_H = 2'd1,
        FMT_W = 2'd2,
        FMT_D = 2'd3
    } elm_fmt_e;

    localparam logic [3:0] OP_CPY_S = 4'd2;
    localparam logic [3:0] OP_CPY_U = 4'd3;
    localparam logic [3:0] OP_INS_G = 4'd4;
    localparam logic [3:0] OP_INS_V = 4'd5;

    localparam logic [5:0] ESC_CODE = 6'h3E;

    typedef struct packed {
        logic       lane_ok;
        logic       esc;
        elm_fmt_e   fmt;
        logic [3:0] idx;
        logic [3:0] op;
        logic [4:0] dst;
    } elm_dec_t;

endpackage

// File: rtl/elm_decode.sv
module elm_decode
    import elm_move_pkg::*;
#(
    parameter int GPR_W = 64
) (
    input  logic [31:0] instr,
    output elm_dec_t    dec,
    output logic        is_copy,
    output logic        is_ins_g,
    output logic        is_ins_v,
    output logic        ri
);
    logic [5:0] dfn;
    logic       op_known;
    logic       needs_gpr;
    logic       wide_blocked;
    logic       unused_bits;

    assign dfn         = instr[21:16];
    assign unused_bits = ^{instr[31:26], instr[15:11], instr[5:0]};

    always_comb begin
        dec      = '0;
        dec.op   = instr[25:22];
        dec.dst  = instr[10:6];
        // prefix code: the count of leading ones picks the lane size
        casez (dfn)
            6'b00????: begin dec.lane_ok = 1'b1; dec.fmt = FMT_B; dec.idx = dfn[3:0];          end
            6'b100???: begin dec.lane_ok = 1'b1; dec.fmt = FMT_H; dec.idx = {1'b0, dfn[2:0]};  end
            6'b1100??: begin dec.lane_ok = 1'b1; dec.fmt = FMT_W; dec.idx = {2'b0, dfn[1:0]};  end
            6'b11100?: begin dec.lane_ok = 1'b1; dec.fmt = FMT_D; dec.idx = {3'b0, dfn[0]};    end
            ESC_CODE:  begin dec.esc = 1'b1; end
            default:   ;
        endcase

        op_known     = (dec.op == OP_CPY_S) || (dec.op == OP_CPY_U) ||
                       (dec.op == OP_INS_G) || (dec.op == OP_INS_V);
        needs_gpr    = (dec.op == OP_CPY_S) || (dec.op == OP_CPY_U) || (dec.op == OP_INS_G);
        wide_blocked = (GPR_W == 32) && (dec.fmt == FMT_D) && needs_gpr;

        ri       = !dec.esc && (!dec.lane_ok || !op_known || wide_blocked);
        is_copy  = !ri && dec.lane_ok && ((dec.op == OP_CPY_S) || (dec.op == OP_CPY_U));
        is_ins_g = !ri && dec.lane_ok && (dec.op == OP_INS_G);
        is_ins_v = !ri && dec.lane_ok && (dec.op == OP_INS_V);
    end

endmodule

// File: rtl/elm_lane_pick.sv
module elm_lane_pick
    import elm_move_pkg::*;
#(
    parameter int GPR_W = 64
) (
    input  logic [VEC_W-1:0] vec,
    input  elm_fmt_e         fmt,
    input  logic [3:0]       idx,
    input  logic             sign_ext,
    output logic [GPR_W-1:0] value
);
    logic [GPR_W-1:0] cand [NFMT];

    for (genvar f = 0; f < NFMT; f++) begin : g_fmt
        localparam int LW = 8 << f;
        localparam int NL = VEC_W / LW;
        localparam int IW = $clog2(NL);
        localparam int SW = $clog2(LW);

        logic [6:0] sh;
        // lane number wraps at the lane count of this format
        assign sh = 7'(idx[IW-1:0]) << SW;

        if (LW >= GPR_W) begin : g_trunc
            assign cand[f] = vec[sh +: GPR_W];
        end else begin : g_ext
            assign cand[f] = {{(GPR_W - LW){sign_ext & vec[sh + 7'(LW - 1)]}}, vec[sh +: LW]};
        end
    end

    assign value = cand[fmt];

endmodule

// File: rtl/elm_lane_merge.sv
module elm_lane_merge
    import elm_move_pkg::*;
(
    input  logic [VEC_W-1:0] base,
    input  logic [63:0]      put,
    input  elm_fmt_e         fmt,
    input  logic [3:0]       idx,
    output logic [VEC_W-1:0] merged
);
    logic [VEC_W-1:0] cand [NFMT];

    for (genvar f = 0; f < NFMT; f++) begin : g_fmt
        localparam int LW = 8 << f;
        localparam int NL = VEC_W / LW;
        localparam int IW = $clog2(NL);
        localparam int SW = $clog2(LW);

        logic [6:0]       sh;
        logic [VEC_W-1:0] mask;
        logic [VEC_W-1:0] lane;

        assign sh     = 7'(idx[IW-1:0]) << SW;
        assign mask   = VEC_W'({LW{1'b1}}) << sh;
        assign lane   = VEC_W'(put[LW-1:0]) << sh;
        assign cand[f] = (base & ~mask) | lane;
    end

    assign merged = cand[fmt];

endmodule

// File: rtl/elm_move_unit.sv
module elm_move_unit
    import elm_move_pkg::*;
#(
    parameter int GPR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       instr,
    input  logic [VEC_W-1:0]  vs_data,
    input  logic [VEC_W-1:0]  vd_data,
    input  logic [GPR_W-1:0]  gpr_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              gpr_we,
    output logic              vr_we,
    output logic [4:0]        wb_addr,
    output logic [GPR_W-1:0]  gpr_wdata,
    output logic [VEC_W-1:0]  vr_wdata,
    output logic              ri_exc,
    output logic              ctl_escape
);
    if (GPR_W != 32 && GPR_W != 64) begin : g_bad_width
        $error("GPR_W must be 32 or 64");
    end

    typedef struct packed {
        logic             valid;
        logic             gwe;
        logic             vwe;
        logic             ri;
        logic             esc;
        logic [4:0]       addr;
        logic [GPR_W-1:0] gdata;
        logic [VEC_W-1:0] vdata;
    } wb_t;

    wb_t st_d, st_q;

    elm_dec_t         dec;
    logic             is_copy, is_ins_g, is_ins_v, dec_ri;
    logic [GPR_W-1:0] picked;
    logic [63:0]      put_val;
    logic [VEC_W-1:0] merged;
    logic             in_fire;

    elm_decode #(.GPR_W(GPR_W)) u_dec (
        .instr    (instr),
        .dec      (dec),
        .is_copy  (is_copy),
        .is_ins_g (is_ins_g),
        .is_ins_v (is_ins_v),
        .ri       (dec_ri)
    );

    elm_lane_pick #(.GPR_W(GPR_W)) u_pick (
        .vec      (vs_data),
        .fmt      (dec.fmt),
        .idx      (dec.idx),
        .sign_ext (dec.op == OP_CPY_S),
        .value    (picked)
    );

    assign put_val = is_ins_g ? 64'(gpr_data) : vs_data[63:0];

    elm_lane_merge u_merge (
        .base   (vd_data),
        .put    (put_val),
        .fmt    (dec.fmt),
        .idx    (dec.idx),
        .merged (merged)
    );

    assign in_ready = !st_q.valid || out_ready;
    assign in_fire  = in_valid && in_ready;

    always_comb begin
        st_d = st_q;
        if (in_ready) begin
            st_d.valid = in_valid;
            st_d.gwe   = in_valid && is_copy;
            st_d.vwe   = in_valid && (is_ins_g || is_ins_v);
            st_d.ri    = in_valid && dec_ri;
            st_d.esc   = in_valid && dec.esc;
            st_d.addr  = in_valid ? dec.dst : 5'd0;
            st_d.gdata = (in_valid && is_copy) ? picked : '0;
            st_d.vdata = (in_valid && (is_ins_g || is_ins_v)) ? merged : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign gpr_we     = st_q.gwe;
    assign vr_we      = st_q.vwe;
    assign wb_addr    = st_q.addr;
    assign gpr_wdata  = st_q.gdata;
    assign vr_wdata   = st_q.vdata;
    assign ri_exc     = st_q.ri;
    assign ctl_escape = st_q.esc;

    // R13: a stalled result does not change
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(wb_addr) && $stable(gpr_wdata)
                                    && $stable(vr_wdata) && $stable(ri_exc));

    // R6: an exception never writes
    a_r6_ri_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        ri_exc |-> !gpr_we && !vr_we);

    // R5: the escape group writes nothing and is not an exception
    a_r5_esc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_escape |-> !ri_exc && !gpr_we && !vr_we && out_valid);

    // R7: at most one register file is written per result
    a_r7_one_file: assert property (@(posedge clk) disable iff (!rst_n)
        !(gpr_we && vr_we));

    // R9: unsigned byte copy leaves the upper bits clear
    a_r9_zext: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && !dec_ri && dec.lane_ok && dec.op == OP_CPY_U && dec.fmt == FMT_B
        |=> gpr_we && gpr_wdata[GPR_W-1:8] == '0);

    // R8: signed byte copy replicates bit 7 upward
    a_r8_sext: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && !dec_ri && dec.lane_ok && dec.op == OP_CPY_S && dec.fmt == FMT_B
        |=> gpr_we && (gpr_wdata[GPR_W-1:7] == '0 || gpr_wdata[GPR_W-1:7] == '1));

    // R10: inserting into byte lane 0 keeps every other byte
    a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire && is_ins_g && dec.fmt == FMT_B && dec.idx == 4'd0
        |=> vr_we && vr_wdata[VEC_W-1:8] == $past(vd_data[VEC_W-1:8]));

endmodule

// File: tb/elm_move_unit_test.sv
`timescale 1ns/1ps
module elm_move_unit_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         out_ready = 1'b1;
    logic [31:0]  instr = '0;
    logic [127:0] vs = '0, vd = '0;
    logic [63:0]  gpr = '0;

    logic         rdy_w, val_w, gwe_w, vwe_w, ri_w, esc_w;
    logic [4:0]   addr_w;
    logic [63:0]  gdat_w;
    logic [127:0] vdat_w;
    logic         rdy_n, val_n, gwe_n, vwe_n, ri_n, esc_n;
    logic [4:0]   addr_n;
    logic [31:0]  gdat_n;
    logic [127:0] vdat_n;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cycles++;

    elm_move_unit #(.GPR_W(64)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_w), .instr(instr),
        .vs_data(vs), .vd_data(vd), .gpr_data(gpr), .out_valid(val_w), .out_ready(out_ready),
        .gpr_we(gwe_w), .vr_we(vwe_w), .wb_addr(addr_w), .gpr_wdata(gdat_w),
        .vr_wdata(vdat_w), .ri_exc(ri_w), .ctl_escape(esc_w));

    elm_move_unit #(.GPR_W(32)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy_n), .instr(instr),
        .vs_data(vs), .vd_data(vd), .gpr_data(gpr[31:0]), .out_valid(val_n), .out_ready(out_ready),
        .gpr_we(gwe_n), .vr_we(vwe_n), .wb_addr(addr_n), .gpr_wdata(gdat_n),
        .vr_wdata(vdat_n), .ri_exc(ri_n), .ctl_escape(esc_n));

    task automatic check(input bit ok, input string tag, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Reference model built from the requirement text
    task automatic model(input int gw, input logic [31:0] iw, output logic [203:0] res,
                         output string tag);
        int dfn, op, fmt, idx, lw;
        bit lane_ok, esc, ri, gwe, vwe;
        logic [127:0] lane, m, v;
        logic [63:0]  g, val;
        dfn = int'(iw[21:16]);
        op  = int'(iw[25:22]);
        lane_ok = 1; esc = 0; fmt = 0; idx = 0;
        if (dfn < 16)                     begin fmt = 0; idx = dfn;        tag = "R1"; end
        else if (dfn >= 32 && dfn < 40)   begin fmt = 1; idx = dfn - 32;   tag = "R2"; end
        else if (dfn >= 48 && dfn < 52)   begin fmt = 2; idx = dfn - 48;   tag = "R3"; end
        else if (dfn == 56 || dfn == 57)  begin fmt = 3; idx = dfn - 56;   tag = "R4"; end
        else begin
            lane_ok = 0;
            esc = (dfn == 62);
            tag = esc ? "R5" : "R6";
        end
        lw = 8 << fmt;
        ri = 0; gwe = 0; vwe = 0; g = '0; v = '0;
        if (lane_ok) begin
            if (op < 2 || op > 5) begin ri = 1; tag = {tag, "/R7"}; end
            else if (gw == 32 && fmt == 3 && op != 5) begin ri = 1; tag = {tag, "/R12"}; end
            else if (op == 2 || op == 3) begin
                gwe = 1;
                tag = {tag, (op == 2) ? "/R8" : "/R9"};
                m = (128'd1 << lw) - 128'd1;
                lane = (vs >> (idx * lw)) & m;
                if (op == 2 && lane[lw-1]) lane = lane | ~m;
                g = lane[63:0];
                if (gw == 32) g[63:32] = '0;
            end else begin
                vwe = 1;
                tag = {tag, (op == 4) ? "/R10" : "/R11"};
                val = (op == 4) ? ((gw == 32) ? {32'd0, gpr[31:0]} : gpr) : vs[63:0];
                m = ((128'd1 << lw) - 128'd1) << (idx * lw);
                v = (vd & ~m) | ((128'(val) << (idx * lw)) & m);
            end
        end else if (!esc) ri = 1;
        res = {ri, esc, gwe, vwe, iw[10:6], g, v};
    endtask

    task automatic compare_both(input logic [31:0] iw);
        logic [203:0] e64, e32;
        string t64, t32;
        model(64, iw, e64, t64);
        model(32, iw, e32, t32);
        check(val_w && {ri_w, esc_w, gwe_w, vwe_w, addr_w, gdat_w, vdat_w} == e64,
              {t64, " w64"}, 256'({ri_w, esc_w, gwe_w, vwe_w, addr_w, gdat_w, vdat_w}), 256'(e64));
        check(val_n && {ri_n, esc_n, gwe_n, vwe_n, addr_n, 32'd0, gdat_n, vdat_n} == e32,
              {t32, " w32"}, 256'({ri_n, esc_n, gwe_n, vwe_n, addr_n, 32'd0, gdat_n, vdat_n}),
              256'(e32));
    endtask

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        finish_run();
    end

    initial begin
        logic [31:0] iw;
        repeat (3) @(negedge clk);
        // R14: reset state
        check(!val_w && !val_n && rdy_w && rdy_n, "R14 reset", 256'({val_w, val_n}), 256'(0));
        rst_n = 1'b1;
        @(negedge clk);

        for (int pat = 0; pat < 3; pat++) begin
            case (pat)
                0: begin vs = {16{8'h81}} ^ {8{16'h0102}}; vd = {16{8'h5A}};
                         gpr = 64'hFEDC_BA98_7654_3210; end
                1: begin vs = {2{64'h7F6E_5D4C_3B2A_1908}}; vd = {128{1'b1}};
                         gpr = 64'h0123_4567_89AB_CDEF; end
                default: begin vs = {$urandom, $urandom, $urandom, $urandom};
                               vd = {$urandom, $urandom, $urandom, $urandom};
                               gpr = {$urandom, $urandom}; end
            endcase
            for (int dfn = 0; dfn < 64; dfn++) begin
                for (int op = 0; op < 16; op++) begin
                    iw = {6'h1E, 4'(op), 6'(dfn), 5'(dfn ^ 5), 5'(op + dfn), 6'h19};
                    instr = iw;
                    in_valid = 1'b1;
                    @(negedge clk);
                    compare_both(iw);
                end
            end
        end

        // R13: stall behaviour
        in_valid = 1'b0;
        @(negedge clk);
        out_ready = 1'b0;
        vs = {16{8'hC3}};
        vd = '0;
        instr = {6'h1E, 4'd2, 6'h05, 5'd1, 5'd9, 6'h19};    // signed copy, byte lane 5
        in_valid = 1'b1;
        @(negedge clk);
        iw = instr;
        instr = {6'h1E, 4'd3, 6'h31, 5'd1, 5'd12, 6'h19};   // unsigned copy, word lane 1
        check(!rdy_w && !rdy_n, "R13 ready low when stalled", 256'({rdy_w, rdy_n}), 256'(0));
        @(negedge clk);
        @(negedge clk);
        compare_both(iw);
        check(gdat_w == 64'hFFFF_FFFF_FFFF_FFC3, "R13 held result",
              256'(gdat_w), 256'(64'hFFFF_FFFF_FFFF_FFC3));
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        compare_both(instr);
        check(gdat_w == 64'h0000_0000_C3C3_C3C3, "R13 second result",
              256'(gdat_w), 256'(64'hC3C3_C3C3));
        @(negedge clk);
        check(!val_w && !val_n, "R13 drains", 256'({val_w, val_n}), 256'(0));
        // R14: data buses are zero when no write occurs
        check(gdat_w == '0 && vdat_w == '0, "R14 idle data", 256'(gdat_w), 256'(0));

        finish_run();
    end

endmodule